// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit carries out one indivisible read-modify-write on a single-ported synchronous memory. A requester presents a base address, a signed 16-bit displacement, an access size, the 8-bit operation selector, the current source-register value and the current R0 value. The unit reads the addressed word, computes the new value, writes it back when the operation calls for it, and then reports the register updates (source register and/or R0) with their write enables for one cycle.

The controller walks through named states. From `ST_IDLE`, an accepted request moves to `ST_READ` when legal, or directly to `ST_DONE` with an error when it is not (`IDLE->READ`, `IDLE->DONE`). `ST_READ` issues the read and always moves to `ST_MODIFY` (`READ->MODIFY`). In `ST_MODIFY` the read data arrives and the new value is computed. The state then goes to `ST_WRITE` when a store is required (`MODIFY->WRITE`), or to `ST_DONE` when a compare-exchange finds a mismatch (`MODIFY->DONE`). `ST_WRITE` always continues to `ST_DONE` (`WRITE->DONE`), and `ST_DONE` always returns to `ST_IDLE` (`DONE->IDLE`).

A lock output tells a surrounding arbiter to keep other masters away from `ST_READ` through `ST_WRITE`. Arbitration itself lies outside the block.

Top module: `amo_rmw_unit`

## Requirements
- R1: The memory address is the base plus the sign-extended 16-bit displacement. The read and the write of one operation use that same address.
- R2: Cycle order: the read is issued one cycle after acceptance, a write is issued two cycles after the read, and `done` follows the last access by one cycle. `mem_lock` is high on every access cycle and on the cycle between them. `busy` is high whenever the unit is not idle, and `req_valid` is ignored while `busy` is high.
- R3: Selector low bits 0x00 (add), 0x40 (or), 0x50 (and) and 0xA0 (xor) store old ⊕ source. Arithmetic wraps modulo the access width.
- R4: Bit 0 of the selector is the fetch flag. With it set, `src_we` rises at done and `src_val` is the pre-update memory value. With it clear on a simple operation, neither register write enable rises.
- R5: Selector 0xE1 (exchange) stores the source value and returns the old memory value on `src_val` with `src_we` high.
- R6: Selector 0xF1 (compare-exchange) stores the source value when the old memory value equals R0 (compared within the access width). In every case it returns the old value on `r0_val` with `r0_we` high, and `src_we` stays low.
- R7: A compare-exchange mismatch issues no write cycle and leaves memory unchanged. `done` comes one cycle earlier than for a writing operation.
- R8: `req_size` encodes 0 = 32-bit and 3 = 64-bit. Codes 1 (halfword) and 2 (byte) are rejected: `done` and `err` rise on the cycle after acceptance, no memory access takes place, and no register write enable rises.
- R9: Any other selector (for example 0xE0, 0xF0, 0x10, 0x03) is rejected in the same way as R8.
- R10: For 32-bit accesses only the low 32 bits take part in the operation and the compare. Returned register values and written data have zero upper halves, and the upper memory word is untouched.
- R11: `done` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_base | input | ADDR_W | Base address register value |
| req_offset | input | OFF_W | Signed displacement |
| req_size | input | 2 | Access size: 0 word, 1 half, 2 byte, 3 double |
| req_op | input | 8 | Operation selector |
| req_src | input | DATA_W | Source register value |
| req_r0 | input | DATA_W | R0 value (compare operand) |
| busy | output | 1 | Unit not idle |
| mem_lock | output | 1 | Hold-off for other memory masters |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Write when high, read when low |
| mem_dword | output | 1 | 64-bit access when high, 32-bit when low |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid one cycle after a read |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request rejected (with done) |
| src_we | output | 1 | Source register update enable |
| src_val | output | DATA_W | Source register update value |
| r0_we | output | 1 | R0 update enable |
| r0_val | output | DATA_W | R0 update value |

## Verification
The bench builds the unit with its defaults: 64-bit address and data, and a 16-bit displacement. These values reach negative displacements, carries that cross the 32-bit boundary in 64-bit adds, and 32-bit compares where the R0 upper bits differ. The memory model decodes eight address bits into 32-bit words, so the 32-bit and 64-bit accesses overlap on the same words. That overlap makes any write into the wrong half visible.

// File: rtl/amo_pkg.sv
package amo_pkg;

    localparam logic [1:0] SZ_WORD  = 2'd0;
    localparam logic [1:0] SZ_DWORD = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_MODIFY,
        ST_WRITE,
        ST_DONE
    } amo_state_e;

    typedef enum logic [2:0] {
        K_ADD,
        K_OR,
        K_AND,
        K_XOR,
        K_XCHG,
        K_CMPX
    } amo_kind_e;

    typedef struct packed {
        amo_kind_e kind;
        logic      fetch;
        logic      dword;
        logic      legal;
    } amo_ctl_t;

endpackage

// File: rtl/amo_decode.sv
module amo_decode
    import amo_pkg::*;
(
    input  logic [7:0] op,
    input  logic [1:0] size,
    output amo_ctl_t   ctl
);

    logic size_ok;
    logic op_ok;
    amo_kind_e kind;

    assign size_ok = (size == SZ_WORD) || (size == SZ_DWORD);

    always_comb begin
        kind  = K_ADD;
        op_ok = 1'b0;
        case (op[7:4])
            4'h0: begin kind = K_ADD;  op_ok = 1'b1;  end
            4'h4: begin kind = K_OR;   op_ok = 1'b1;  end
            4'h5: begin kind = K_AND;  op_ok = 1'b1;  end
            4'hA: begin kind = K_XOR;  op_ok = 1'b1;  end
            4'hE: begin kind = K_XCHG; op_ok = op[0]; end
            4'hF: begin kind = K_CMPX; op_ok = op[0]; end
            default: begin kind = K_ADD; op_ok = 1'b0; end
        endcase
        if (op[3:1] != 3'b000) op_ok = 1'b0;
    end

    assign ctl.kind  = kind;
    assign ctl.fetch = op[0];
    assign ctl.dword = (size == SZ_DWORD);
    assign ctl.legal = size_ok && op_ok;

endmodule

// File: rtl/amo_alu.sv
module amo_alu
    import amo_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  amo_kind_e          kind,
    input  logic               dword,
    input  logic [DATA_W-1:0]  old_raw,
    input  logic [DATA_W-1:0]  src,
    input  logic [DATA_W-1:0]  r0,
    output logic [DATA_W-1:0]  new_val,
    output logic [DATA_W-1:0]  old_ext,
    output logic               need_wr
);

    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] res;
    logic              equal;

    always_comb begin
        unique case (kind)
            K_ADD:   res = old_raw + src;
            K_OR:    res = old_raw | src;
            K_AND:   res = old_raw & src;
            K_XOR:   res = old_raw ^ src;
            K_XCHG:  res = src;
            K_CMPX:  res = src;
            default: res = src;
        endcase
    end

    assign equal   = dword ? (old_raw == r0)
                           : (old_raw[HALF_W-1:0] == r0[HALF_W-1:0]);
    assign new_val = dword ? res : {{HALF_W{1'b0}}, res[HALF_W-1:0]};
    assign old_ext = dword ? old_raw : {{HALF_W{1'b0}}, old_raw[HALF_W-1:0]};
    assign need_wr = (kind != K_CMPX) || equal;

endmodule

// File: rtl/amo_rmw_unit.sv
module amo_rmw_unit
    import amo_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 64,
    parameter int OFF_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic [1:0]        req_size,
    input  logic [7:0]        req_op,
    input  logic [DATA_W-1:0] req_src,
    input  logic [DATA_W-1:0] req_r0,
    output logic              busy,
    output logic              mem_lock,
    output logic              mem_en,
    output logic              mem_we,
    output logic              mem_dword,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic              err,
    output logic              src_we,
    output logic [DATA_W-1:0] src_val,
    output logic              r0_we,
    output logic [DATA_W-1:0] r0_val
);

    localparam int EXT_W = ADDR_W - OFF_W;

    amo_state_e        state_q, state_d;
    amo_ctl_t          ctl_in, ctl_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] src_q, r0_q, old_q, new_q;
    logic              wr_q, err_q;
    logic [DATA_W-1:0] new_val, old_ext;
    logic              need_wr;

    amo_decode u_decode (
        .op   (req_op),
        .size (req_size),
        .ctl  (ctl_in)
    );

    amo_alu #(.DATA_W(DATA_W)) u_alu (
        .kind    (ctl_q.kind),
        .dword   (ctl_q.dword),
        .old_raw (mem_rdata),
        .src     (src_q),
        .r0      (r0_q),
        .new_val (new_val),
        .old_ext (old_ext),
        .need_wr (need_wr)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ctl_in.legal ? ST_READ : ST_DONE;
            ST_READ:   state_d = ST_MODIFY;
            ST_MODIFY: state_d = need_wr ? ST_WRITE : ST_DONE;
            ST_WRITE:  state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ctl_q   <= '{kind: K_ADD, fetch: 1'b0, dword: 1'b0, legal: 1'b0};
            addr_q  <= '0;
            src_q   <= '0;
            r0_q    <= '0;
            old_q   <= '0;
            new_q   <= '0;
            wr_q    <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                ctl_q  <= ctl_in;
                addr_q <= req_base + {{EXT_W{req_offset[OFF_W-1]}}, req_offset};
                src_q  <= req_src;
                r0_q   <= req_r0;
                err_q  <= !ctl_in.legal;
            end
            if (state_q == ST_MODIFY) begin
                old_q <= old_ext;
                new_q <= new_val;
                wr_q  <= need_wr;
            end
        end
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        mem_lock  = (state_q == ST_READ) || (state_q == ST_MODIFY) || (state_q == ST_WRITE);
        mem_en    = (state_q == ST_READ) || (state_q == ST_WRITE);
        mem_we    = (state_q == ST_WRITE);
        mem_dword = ctl_q.dword;
        mem_addr  = addr_q;
        mem_wdata = new_q;
        done      = (state_q == ST_DONE);
        err       = done && err_q;
        src_we    = done && !err_q && ctl_q.fetch && (ctl_q.kind != K_CMPX);
        src_val   = old_q;
        r0_we     = done && !err_q && (ctl_q.kind == K_CMPX);
        r0_val    = old_q;
    end

    AST_LOCK_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> mem_lock); // R2
    AST_WRITE_AFTER_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> $past(mem_lock)); // R2
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_lock && $past(mem_lock)) |-> $stable(mem_addr)); // R1
    AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && req_valid && !ctl_in.legal) |=> (done && !mem_en)); // R8
    AST_MISMATCH_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MODIFY && !need_wr) |=> !mem_en); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_CMPX_R0_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        r0_we |-> !src_we); // R6
    AST_WR_MATCHES_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> wr_q); // R7

endmodule

// File: tb/amo_rmw_unit_tb_top.sv
`timescale 1ns/1ps
module amo_rmw_unit_tb_top;

    typedef struct {
        logic        err;
        logic        swe;
        logic [63:0] sval;
        logic        rwe;
        logic [63:0] rval;
        int          nwr;
        int          nacc;
        int          lat;
        logic [63:0] addr;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_base = '0;
    logic [15:0] req_offset = '0;
    logic [1:0]  req_size = '0;
    logic [7:0]  req_op = '0;
    logic [63:0] req_src = '0;
    logic [63:0] req_r0 = '0;
    logic        busy, mem_lock, mem_en, mem_we, mem_dword;
    logic [63:0] mem_addr, mem_wdata;
    logic [63:0] mem_rdata = '0;
    logic        done, err, src_we, r0_we;
    logic [63:0] src_val, r0_val;

    logic [31:0] mem   [64];
    logic [31:0] ref_m [64];
    exp_t        q[$];
    int          checks = 0;
    int          errors = 0;
    int          ncyc = 0, start = 0, nacc = 0, nwr = 0;
    logic [63:0] last_addr = '0;
    bit          finished = 0;
    wire  [5:0]  bidx = mem_addr[7:2];

    always #2 clk = ~clk;

    amo_rmw_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_base(req_base),
        .req_offset(req_offset), .req_size(req_size), .req_op(req_op),
        .req_src(req_src), .req_r0(req_r0), .busy(busy), .mem_lock(mem_lock),
        .mem_en(mem_en), .mem_we(mem_we), .mem_dword(mem_dword),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done), .err(err), .src_we(src_we), .src_val(src_val),
        .r0_we(r0_we), .r0_val(r0_val)
    );

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                mem[bidx] <= mem_wdata[31:0];
                if (mem_dword) mem[bidx + 6'd1] <= mem_wdata[63:32];
            end else begin
                mem_rdata <= mem_dword ? {mem[bidx + 6'd1], mem[bidx]} : {32'h0, mem[bidx]};
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected items and compares when the design completes
    always @(negedge clk) begin
        ncyc++;
        if (rst_n) begin
            if (req_valid && !busy) begin
                start = ncyc; nacc = 0; nwr = 0;
            end
            if (mem_en) begin
                nacc++;
                chk(nacc == 1 || mem_addr == last_addr, "R1 same address on write", mem_addr, last_addr);
                last_addr = mem_addr;
                if (mem_we) nwr++;
            end
            if (done) begin
                if (q.size() == 0) begin
                    chk(0, "R2 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(err == e.err, "R8/R9 err flag", err, e.err);
                    chk(src_we == e.swe, "R4 src_we", src_we, e.swe);
                    if (e.swe) chk(src_val == e.sval, "R4/R5 src_val", src_val, e.sval);
                    chk(r0_we == e.rwe, "R6 r0_we", r0_we, e.rwe);
                    if (e.rwe) chk(r0_val == e.rval, "R6 r0_val", r0_val, e.rval);
                    chk(nwr == e.nwr, "R7 write cycles", nwr, e.nwr);
                    chk(nacc == e.nacc, "R8 access cycles", nacc, e.nacc);
                    chk(ncyc - start == e.lat, "R2 latency", ncyc - start, e.lat);
                    if (e.nacc > 0) chk(last_addr == e.addr, "R1 address", last_addr, e.addr);
                    for (int i = 0; i < 64; i++)
                        if (mem[i] !== ref_m[i]) chk(0, "R3/R10 memory word", mem[i], ref_m[i]);
                    checks++;
                end
            end
        end
    end

    // Driver: computes the expected outcome from the requirements and pushes it
    task automatic run(input logic [63:0] base, input logic [15:0] off, input logic [1:0] size,
                       input logic [7:0] op, input logic [63:0] src, input logic [63:0] r0,
                       input bit pulse);
        exp_t        e;
        logic [63:0] a, oldv, res, s, r;
        int          ix;
        bit          dw, legal, wr, isx, isc;
        a  = base + {{48{off[15]}}, off};
        ix = int'(a[7:2]);
        dw = (size == 2'd3);
        isx = (op == 8'hE1);
        isc = (op == 8'hF1);
        legal = (size == 2'd0 || size == 2'd3) &&
                (isx || isc || op inside {8'h00, 8'h01, 8'h40, 8'h41, 8'h50, 8'h51, 8'hA0, 8'hA1});
        oldv = dw ? {ref_m[(ix + 1) % 64], ref_m[ix]} : {32'h0, ref_m[ix]};
        s = dw ? src : {32'h0, src[31:0]};
        r = dw ? r0  : {32'h0, r0[31:0]};
        case (op[7:4])
            4'h0: res = oldv + s;
            4'h4: res = oldv | s;
            4'h5: res = oldv & s;
            4'hA: res = oldv ^ s;
            default: res = s;
        endcase
        if (!dw) res[63:32] = 32'h0;
        wr = legal && (!isc || oldv == r);
        e.err  = !legal;
        e.swe  = legal && op[0] && !isc;
        e.sval = oldv;
        e.rwe  = legal && isc;
        e.rval = oldv;
        e.nwr  = wr ? 1 : 0;
        e.nacc = !legal ? 0 : (wr ? 2 : 1);
        e.lat  = !legal ? 1 : (wr ? 4 : 3);
        e.addr = a;
        if (wr) begin
            ref_m[ix] = res[31:0];
            if (dw) ref_m[(ix + 1) % 64] = res[63:32];
        end
        q.push_back(e);
        @(negedge clk);
        req_valid = 1; req_base = base; req_offset = off; req_size = size;
        req_op = op; req_src = src; req_r0 = r0;
        @(negedge clk);
        req_valid = 0;
        if (pulse) begin
            // R2: a request presented while busy must be ignored
            req_valid = 1; req_op = 8'hA1; req_size = 2'd3; req_src = 64'hFFFF_FFFF_FFFF_FFFF;
            @(negedge clk);
            req_valid = 0;
        end
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            mem[i]   = 32'h1000_0000 + i * 32'h0101_0101;
            ref_m[i] = 32'h1000_0000 + i * 32'h0101_0101;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !done && !mem_en && !mem_lock, "R2 reset state", {busy, done, mem_en, mem_lock}, 0);
        // R3/R4 add with fetch, 32-bit, negative displacement
        run(64'h120, 16'hFF00, 2'd0, 8'h01, 64'hAAAA_0000_0000_0005, 64'h0, 0);
        // R3 add no fetch 64-bit, carry across halves
        mem[10] = 32'hFFFF_FFFF; ref_m[10] = 32'hFFFF_FFFF;
        run(64'h28, 16'h0000, 2'd3, 8'h00, 64'h1, 64'h0, 0);
        // R10 32-bit add wraps, upper word untouched
        run(64'h30, 16'h0010, 2'd0, 8'h01, 64'h0000_0000_FFFF_FFFF, 64'h0, 0);
        // R3 or / and / xor
        run(64'h48, 16'h0000, 2'd3, 8'h41, 64'h00F0_0000_0000_0F00, 64'h0, 0);
        run(64'h50, 16'h0004, 2'd0, 8'h51, 64'h0000_0000_0F0F_0F0F, 64'h0, 0);
        run(64'h60, 16'hFFF8, 2'd3, 8'hA0, 64'h1234_5678_9ABC_DEF0, 64'h0, 1);
        // R5 exchange
        run(64'h70, 16'h0000, 2'd3, 8'hE1, 64'hDEAD_BEEF_CAFE_F00D, 64'h0, 0);
        run(64'h80, 16'h0004, 2'd0, 8'hE1, 64'h5555_5555_1111_2222, 64'h0, 0);
        // R6 compare-exchange match, 64-bit
        run(64'h90, 16'h0000, 2'd3, 8'hF1, 64'h0BAD_F00D_0000_0001,
            {ref_m[37], ref_m[36]}, 0);
        // R6/R10 compare-exchange match on low half only, 32-bit
        run(64'hA0, 16'h0000, 2'd0, 8'hF1, 64'h7777_7777, {32'hFFFF_0000, ref_m[40]}, 0);
        // R7 compare-exchange mismatch
        run(64'hB0, 16'h0000, 2'd3, 8'hF1, 64'h1, 64'h0, 0);
        run(64'hC0, 16'h0000, 2'd0, 8'hF1, 64'h1, 64'h0, 0);
        // R8 byte and halfword rejected
        run(64'hD0, 16'h0000, 2'd1, 8'h01, 64'h1, 64'h0, 0);
        run(64'hD0, 16'h0000, 2'd2, 8'h00, 64'h1, 64'h0, 0);
        // R9 unsupported selectors
        run(64'hE0, 16'h0000, 2'd3, 8'hE0, 64'h1, 64'h0, 0);
        run(64'hE0, 16'h0000, 2'd3, 8'hF0, 64'h1, 64'h0, 0);
        run(64'hE0, 16'h0000, 2'd0, 8'h10, 64'h1, 64'h0, 0);
        run(64'hE0, 16'h0000, 2'd0, 8'h03, 64'h1, 64'h0, 0);
        // R4 simple op without fetch: no register writes
        run(64'hF0, 16'h0000, 2'd0, 8'h40, 64'h8000_0001, 64'h0, 0);
        // R11 no extra done after activity
        repeat (3) @(negedge clk);
        chk(!done && !busy, "R11 quiet after completion", {done, busy}, 0);
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL R2 watchdog actual=%h expected=%h", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule